// File: doc/BRIEF.md
# Asynchronous Bus Read Target

This block is the target side of a device on a 32-bit asynchronous, strobe-handshaked bus. It watches the active-low address and data strobes, the read/write line, the two transfer-size bits and the address. It answers read cycles whose address falls inside a window set by a base/mask parameter pair. For such a cycle it fetches a word from a local memory through a simple request interface with a fixed latency set by a parameter. It then puts the addressed bytes on the correct byte lanes, raises a two-bit acknowledge that reports its port width, and optionally flags the data as not cacheable.

The handshake is fully interlocked. Data and acknowledge stay on the bus for as long as both strobes remain asserted. As soon as either strobe is seen negated, everything is withdrawn. The block does not acknowledge again until it has seen both strobes negated, so a leftover acknowledge cannot end the next cycle early. Bus drivers are modelled as output enables: `data_oe_o` for each byte lane, and `ack_oe_o` for the acknowledge and cache-inhibit lines.

The controller has four states, named in the list below.
- ST_REARM: the reset state. The block waits here until both strobes are seen negated.
- ST_IDLE: the block waits for a decoded read.
- ST_FETCH: a memory request is outstanding.
- ST_DRIVE: data and acknowledge are on the bus.

It has five transitions, named in the list below.
- REARM→IDLE: taken when both strobes are negated.
- IDLE→FETCH: taken on a decoded read.
- FETCH→DRIVE: taken when the latency count expires.
- FETCH→REARM: an abort, taken when either strobe negates during the fetch.
- DRIVE→REARM: a release, taken when either strobe negates.

Top module: `abus_read_target`

## Requirements
- R1: The block responds only when both strobes are asserted (low), read/write is 1 (read), and (addr & BASE_MASK) == BASE_ADDR. In every other case all output enables stay 0.
- R2: Byte-lane enables use this mapping: `data_oe_o[3]` covers bits 31:24 (byte offset 0) and `data_oe_o[0]` covers bits 7:0 (byte offset 3). The transfer size gives the byte count: 00 means 4 bytes, 01 means 1 byte, 10 means 2 bytes and 11 means 3 bytes. For a 32-bit port, the offsets from addr[1:0] up to the count, capped at offset 3, are enabled.
- R3: On an enabled lane for byte offset k, the data is byte k of the fetched word, counting from its most significant byte. Lanes that are not enabled read 0.
- R4: While acknowledging, `ack_o` carries 11 for a 32-bit port, 10 for a 16-bit port and 01 for an 8-bit port, with `ack_oe_o` set to 1. Otherwise `ack_o` is 00 and `ack_oe_o` is 0.
- R5: `ci_o` equals the CACHE_INH parameter while acknowledging and is 0 otherwise.
- R6: `mem_req_o` is a one-cycle pulse, and `mem_addr_o` is addr[MEM_AW+1:2] for a 32-bit port. The read data is taken MEM_LAT cycles after the request cycle. The acknowledge appears after the (MEM_LAT+4)th rising edge following assertion of the strobes.
- R7: While both strobes stay asserted, acknowledge and data stay driven and unchanged, however long that lasts.
- R8: When either strobe negates, all enables are 0 after the third rising edge that follows.
- R9: After a release, no new acknowledge is given until both strobes have been seen negated, even if the negated strobe is asserted again.
- R10: After reset all enables are 0. A read already in progress when reset ends is not acknowledged.
- R11: If a strobe negates while the fetch is outstanding, no acknowledge is given for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| as_ni | input | 1 | Address strobe, active low, asynchronous |
| ds_ni | input | 1 | Data strobe, active low, asynchronous |
| rnw_i | input | 1 | 1 = read, 0 = write |
| size_i | input | 2 | Transfer size code |
| addr_i | input | 32 | Bus address |
| data_o | output | 32 | Read data toward the bus |
| data_oe_o | output | 4 | Per-lane drive enable |
| ack_o | output | 2 | Acknowledge / port-width code |
| ack_oe_o | output | 1 | Drive enable for acknowledge and cache-inhibit |
| ci_o | output | 1 | Cache-inhibit flag |
| mem_req_o | output | 1 | Local memory read request pulse |
| mem_addr_o | output | MEM_AW | Local memory word address |
| mem_rdata_i | input | PORT_W | Local memory read data |

## Verification
The hardest situation to reach is the re-arm guard. Here the address strobe stays asserted while only the data strobe drops and then returns, which looks like a new cycle to a block without the guard. The bench builds this case directly: it negates only the data strobe, waits for the release, reasserts it, and watches the acknowledge stay off for many cycles. A second case the bench reaches is a cycle already under way when reset is released. Its memory model returns valid data only in the exact cycle the latency rule names, so a fetch that samples too early or too late produces wrong lane data.

// File: rtl/abus_pkg.sv
package abus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DRIVE,
        ST_REARM
    } tgt_state_e;

    // Acknowledge code for a given port width in bits.
    function automatic logic [1:0] ack_code(input int port_w);
        if (port_w == 32) return 2'b11;
        if (port_w == 16) return 2'b10;
        return 2'b01;
    endfunction

endpackage

// File: rtl/abus_sync.sv
module abus_sync #(
    parameter int           W       = 2,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    chain[s] <= RST_VAL;
                end else begin
                    if (s == 0) chain[s] <= d_i;
                    else        chain[s] <= chain[(s == 0) ? 0 : s - 1];
                end
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/abus_lanes.sv
module abus_lanes #(
    parameter int PORT_W = 32
) (
    input  logic [1:0]        size_i,
    input  logic [1:0]        addr_lo_i,
    input  logic [PORT_W-1:0] word_i,
    output logic [3:0]        lane_en_o,
    output logic [31:0]       lane_data_o
);
    localparam int NLANES = PORT_W / 8;

    int first_k;
    int last_k;

    always_comb begin
        first_k = int'(addr_lo_i) % NLANES;
        last_k  = first_k + ((size_i == 2'b00) ? 4 : int'(size_i)) - 1;
    end

    genvar k;
    generate
        for (k = 0; k < 4; k++) begin : g_lane
            if (k < NLANES) begin : g_used
                assign lane_en_o[3-k] = (k >= first_k) && (k <= last_k);
                assign lane_data_o[31-8*k -: 8] =
                    lane_en_o[3-k] ? word_i[PORT_W-1-8*k -: 8] : 8'h00;
            end else begin : g_unused
                assign lane_en_o[3-k]           = 1'b0;
                assign lane_data_o[31-8*k -: 8] = 8'h00;
            end
        end
    endgenerate
endmodule

// File: rtl/abus_read_target.sv
module abus_read_target
    import abus_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR   = 32'h0001_0000,
    parameter logic [31:0] BASE_MASK   = 32'hFFFF_0000,
    parameter int          PORT_W      = 32,
    parameter int          MEM_LAT     = 3,
    parameter int          MEM_AW      = 8,
    parameter int          SYNC_STAGES = 2,
    parameter bit          CACHE_INH   = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              as_ni,
    input  logic              ds_ni,
    input  logic              rnw_i,
    input  logic [1:0]        size_i,
    input  logic [31:0]       addr_i,
    output logic [31:0]       data_o,
    output logic [3:0]        data_oe_o,
    output logic [1:0]        ack_o,
    output logic              ack_oe_o,
    output logic              ci_o,
    output logic              mem_req_o,
    output logic [MEM_AW-1:0] mem_addr_o,
    input  logic [PORT_W-1:0] mem_rdata_i
);
    localparam int          OFF_BITS = $clog2(PORT_W / 8);
    localparam int          CNT_W    = $clog2(MEM_LAT + 2);
    localparam logic [CNT_W-1:0] LAT_C = CNT_W'(MEM_LAT);
    localparam logic [1:0]  ACK_CODE = ack_code(PORT_W);

    tgt_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [31:0]       addr_q;
    logic [1:0]        size_q;
    logic [PORT_W-1:0] word_q;
    logic [1:0]        strb_act;
    logic              as_act, ds_act, both_act, start;
    logic [3:0]        lane_en;
    logic [31:0]       lane_data;

    // Synchronized strobes, active high. Reset value is "asserted" so that
    // the re-arm state waits for a real negation after reset.
    abus_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    ({~as_ni, ~ds_ni}),
        .q_o    (strb_act)
    );

    assign as_act   = strb_act[1];
    assign ds_act   = strb_act[0];
    assign both_act = as_act && ds_act;
    assign start    = both_act && rnw_i && ((addr_i & BASE_MASK) == BASE_ADDR);

    abus_lanes #(.PORT_W(PORT_W)) u_lanes (
        .size_i      (size_q),
        .addr_lo_i   (addr_q[1:0]),
        .word_i      (word_q),
        .lane_en_o   (lane_en),
        .lane_data_o (lane_data)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_FETCH;
            ST_FETCH: begin
                if (!both_act)           state_d = ST_REARM;   // abort
                else if (cnt_q == LAT_C) state_d = ST_DRIVE;
            end
            ST_DRIVE: if (!both_act) state_d = ST_REARM;       // release
            ST_REARM: if (!as_act && !ds_act) state_d = ST_IDLE;
            default:  state_d = ST_REARM;
        endcase
    end

    // State register and captured cycle data.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_REARM;
            cnt_q   <= '0;
            addr_q  <= '0;
            size_q  <= '0;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        addr_q <= addr_i;
                        size_q <= size_i;
                        cnt_q  <= '0;
                    end
                end
                ST_FETCH: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAT_C) word_q <= mem_rdata_i;
                end
                default: ;
            endcase
        end
    end

    // Outputs.
    always_comb begin
        ack_oe_o   = (state_q == ST_DRIVE);
        ack_o      = ack_oe_o ? ACK_CODE : 2'b00;
        ci_o       = ack_oe_o && CACHE_INH;
        data_oe_o  = ack_oe_o ? lane_en : 4'b0000;
        data_o     = ack_oe_o ? lane_data : 32'h0;
        mem_req_o  = (state_q == ST_FETCH) && (cnt_q == '0);
        mem_addr_o = addr_q[OFF_BITS +: MEM_AW];
    end
endmodule

module abus_read_target_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        as_act,
    input logic        ds_act,
    input logic        ack_oe_o,
    input logic [1:0]  ack_o,
    input logic        ci_o,
    input logic [3:0]  data_oe_o,
    input logic [31:0] data_o,
    input logic        mem_req_o
);
    assert_idle_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ack_oe_o |-> (ack_o == 2'b00) && (data_oe_o == 4'b0000) && (data_o == 32'h0));

    assert_lanes_present_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_oe_o |-> (data_oe_o != 4'b0000));

    assert_ci_with_ack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ci_o |-> ack_oe_o);

    assert_req_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_req_o |=> !mem_req_o);

    assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_oe_o && as_act && ds_act) |=> (ack_oe_o && $stable(data_o) && $stable(data_oe_o)));

    assert_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_oe_o && !(as_act && ds_act)) |=> !ack_oe_o);

    assert_no_req_while_ack_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_oe_o |-> !mem_req_o);
endmodule

bind abus_read_target abus_read_target_chk u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .as_act    (as_act),
    .ds_act    (ds_act),
    .ack_oe_o  (ack_oe_o),
    .ack_o     (ack_o),
    .ci_o      (ci_o),
    .data_oe_o (data_oe_o),
    .data_o    (data_o),
    .mem_req_o (mem_req_o)
);

// File: tb/abus_read_target_tb.sv
module abus_read_target_tb_top;
    localparam int  MEM_LAT = 3;
    localparam time CLK_P   = 20ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        as_n = 1'b1, ds_n = 1'b1, rnw = 1'b1;
    logic [1:0]  size = 2'b00;
    logic [31:0] addr = 32'h0;
    logic [31:0] data;
    logic [3:0]  data_oe;
    logic [1:0]  ack;
    logic        ack_oe, ci, mem_req;
    logic [7:0]  mem_addr;
    logic [31:0] mem_rdata;

    int n_chk = 0;
    int n_bad = 0;
    int since = 100;
    int req_cnt = 0;
    logic [7:0] last_req_addr = 8'h0;

    always #(CLK_P/2) clk = ~clk;

    abus_read_target #(.MEM_LAT(MEM_LAT)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .as_ni(as_n), .ds_ni(ds_n), .rnw_i(rnw),
        .size_i(size), .addr_i(addr), .data_o(data), .data_oe_o(data_oe),
        .ack_o(ack), .ack_oe_o(ack_oe), .ci_o(ci), .mem_req_o(mem_req),
        .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata)
    );

    function automatic logic [31:0] pat(input logic [7:0] a);
        return {a, ~a, a ^ 8'h5A, 8'hC3};
    endfunction

    function automatic logic [31:0] expand(input logic [3:0] m);
        return {{8{m[3]}}, {8{m[2]}}, {8{m[1]}}, {8{m[0]}}};
    endfunction

    // Memory model: data valid only MEM_LAT cycles after the request cycle.
    always @(posedge clk) begin
        if (mem_req) begin
            since         <= 1;
            req_cnt       <= req_cnt + 1;
            last_req_addr <= mem_addr;
        end else if (since < 100) begin
            since <= since + 1;
        end
    end
    assign mem_rdata = (((mem_req ? 0 : since)) == MEM_LAT) ? pat(mem_addr) : 32'hDEAD_BEEF;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic strobes(input logic v);
        @(negedge clk);
        as_n = v;
        ds_n = v;
    endtask

    task automatic wait_ack(output int edges);
        edges = 0;
        do begin
            @(posedge clk);
            #1;
            edges++;
        end while (!ack_oe && edges < 40);
    endtask

    task automatic quiet_for(input int cyc, input string req);
        bit seen = 0;
        for (int i = 0; i < cyc; i++) begin
            @(posedge clk);
            #1;
            if (ack_oe || data_oe != 4'b0 || ci || ack != 2'b00) seen = 1;
        end
        chk(!seen, req, "outputs stayed released", {63'b0, seen}, 64'h0);
    endtask

    // {addr, size, rnw, hit, mask}
    localparam logic [39:0] VEC [10] = '{
        {32'h0001_0040, 2'b00, 1'b1, 1'b1, 4'b1111},
        {32'h0001_0041, 2'b01, 1'b1, 1'b1, 4'b0100},
        {32'h0001_0083, 2'b01, 1'b1, 1'b1, 4'b0001},
        {32'h0001_0101, 2'b10, 1'b1, 1'b1, 4'b0110},
        {32'h0001_0103, 2'b10, 1'b1, 1'b1, 4'b0001},
        {32'h0001_0105, 2'b11, 1'b1, 1'b1, 4'b0111},
        {32'h0001_0206, 2'b11, 1'b1, 1'b1, 4'b0011},
        {32'h0001_03FA, 2'b00, 1'b1, 1'b1, 4'b0011},
        {32'h0002_0040, 2'b00, 1'b1, 1'b0, 4'b0000},
        {32'h0001_0040, 2'b00, 1'b0, 1'b0, 4'b0000}
    };

    initial begin
        #(CLK_P * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int e;
        int reqs0;
        logic [31:0] held;

        // R10: cycle in progress across reset is never acknowledged
        addr = 32'h0001_0040; size = 2'b00; rnw = 1'b1;
        as_n = 1'b0; ds_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk(!ack_oe && data_oe == 4'b0 && !mem_req, "R10", "reset state", {59'b0, ack_oe, data_oe}, 64'h0);
        @(negedge clk);
        rst_n = 1'b1;
        quiet_for(20, "R10");
        strobes(1'b1);
        repeat (4) @(posedge clk);

        // Table walk: R1 R2 R3 R4 R5 R6 R8
        for (int v = 0; v < 10; v++) begin
            @(negedge clk);
            addr = VEC[v][39:8]; size = VEC[v][7:6]; rnw = VEC[v][5];
            reqs0 = req_cnt;
            as_n = 1'b0; ds_n = 1'b0;
            if (VEC[v][4]) begin
                wait_ack(e);
                chk(e == MEM_LAT + 4, "R6", "ack latency", e, MEM_LAT + 4);
                chk(last_req_addr == addr[9:2] && req_cnt == reqs0 + 1, "R6", "memory request",
                    last_req_addr, addr[9:2]);
                chk(ack == 2'b11, "R4", "ack code", ack, 2'b11);
                chk(ci == 1'b1, "R5", "cache inhibit", ci, 1);
                chk(data_oe == VEC[v][3:0], "R2", "lane enables", data_oe, VEC[v][3:0]);
                chk(data == (pat(addr[9:2]) & expand(VEC[v][3:0])), "R3", "lane data",
                    data, pat(addr[9:2]) & expand(VEC[v][3:0]));
                strobes(1'b1);
                e = 0;
                do begin
                    @(posedge clk);
                    #1;
                    e++;
                end while (ack_oe && e < 20);
                chk(e == 3 && data_oe == 4'b0, "R8", "release edges", e, 3);
            end else begin
                quiet_for(MEM_LAT + 12, "R1");
                chk(req_cnt == reqs0, "R1", "no memory request", req_cnt, reqs0);
                strobes(1'b1);
            end
            repeat (4) @(posedge clk);
        end

        // R7: long hold
        @(negedge clk);
        addr = 32'h0001_0044; size = 2'b00; rnw = 1'b1;
        as_n = 1'b0; ds_n = 1'b0;
        wait_ack(e);
        held = data;
        repeat (30) @(posedge clk);
        #1;
        chk(ack_oe && data == held && data == pat(8'h11), "R7", "hold while strobes asserted", data, pat(8'h11));

        // R8 with DS only, then R9 re-arm guard
        @(negedge clk);
        ds_n = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk(!ack_oe, "R8", "release on data strobe only", ack_oe, 0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        ds_n = 1'b0;
        quiet_for(25, "R9");
        strobes(1'b1);
        repeat (4) @(posedge clk);
        strobes(1'b0);
        wait_ack(e);
        chk(e == MEM_LAT + 4, "R9", "acknowledge after full re-arm", e, MEM_LAT + 4);
        strobes(1'b1);
        repeat (5) @(posedge clk);

        // R11: abort during fetch
        @(negedge clk);
        addr = 32'h0001_0048;
        as_n = 1'b0; ds_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        as_n = 1'b1; ds_n = 1'b1;
        quiet_for(15, "R11");
        strobes(1'b0);
        wait_ack(e);
        chk(e == MEM_LAT + 4 && data == pat(8'h12), "R11", "next cycle after abort", data, pat(8'h12));
        strobes(1'b1);
        repeat (5) @(posedge clk);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule